// File: doc/BRIEF.md
# Parallel Instruction-Boundary Parser

This block sits between an instruction fetch buffer and the decoders of a wide front end. It takes a window of consecutive 32-bit words and finds, in a single pass, where each variable-length instruction begins. Only words whose major opcode has top bits 001 can be longer than one word. They carry a constant flag. When the flag is set, a 32-bit or 64-bit constant follows in the next one or two words. Every other word is a complete one-word instruction.

Each word of the window has its own small length decoder, which works out the length as if an instruction started there. Each decoder's "next start" pointer is then combined by repeated pointer doubling, starting from word 0. This marks every true instruction start without a word-by-word walk. Up to a fixed number of instructions are listed in ascending order, each with its start index, its length and its two operand-negate routing bits. A word count tells the refill logic how far to advance. Results are registered and appear one cycle after the window is presented.

Top module: `ibp_parse_top`

## Requirements
- R1: The length of an instruction starting at a word is taken from the word as follows. If bits 31:29 are 001 and bit 15 (constant flag) is 1, the length is 2 words when bit 12 (wide flag) is 0 and 3 words when bit 12 is 1. Every other word is 1 word long.
- R2: Word 0 is always an instruction start. Each further start lies at the previous start plus that instruction's R1 length. Words that fall inside an instruction are never starts, whatever their content.
- R3: An instruction whose R1 length would carry it past the last word of the window is not emitted. No start at or after it is reported, and the consumed-word count stops before it.
- R4: At most MAX_OUT (default 16) instructions are emitted per window. The lowest-addressed starts are the ones kept. `start_count` equals the number of set bits in `start_mask`, which marks exactly the emitted starts.
- R5: Slot k of `start_idx` (bits k*5 +: 5) holds the word index of the k-th emitted start, in ascending order. Slots at and above `start_count` read 0.
- R6: Slot k of `start_len` (bits k*2 +: 2) holds the R1 length, from 1 to 3, of the k-th emitted instruction. Unused slots read 0.
- R7: Slot k of `start_neg` (bits k*2 +: 2) holds bit 14 (negate source 1) in bit 1 and bit 13 (negate source 2) in bit 0 of the k-th emitted start word, for every opcode. Unused slots read 0.
- R8: `words_used` equals the sum of the lengths of the emitted instructions. This is the index just past the last emitted instruction.
- R9: Results appear one clock after `in_valid` is high, and `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, all result outputs hold their values. After reset, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window on `in_words` is to be parsed |
| in_words | input | NUM_WORDS*32 | Word i at bits i*32 +: 32 |
| out_valid | output | 1 | Results below belong to the previous valid window |
| start_mask | output | NUM_WORDS | Bit i set when word i is an emitted start |
| start_idx | output | MAX_OUT*5 | Packed start indices, ascending |
| start_len | output | MAX_OUT*2 | Packed instruction lengths in words |
| start_neg | output | MAX_OUT*2 | Packed negate routing bits per instruction |
| start_count | output | 5 | Number of emitted instructions |
| words_used | output | 6 | Words consumed by the emitted instructions |

## Verification
The hardest case to reach is a window whose instruction chain lands on a multi-word instruction that hangs off the end. Uniform random words rarely build such a chain while staying under the slot limit. Directed windows therefore fill the buffer with two- and three-word instructions, so that the chain ends exactly at words 30 and 31 with a constant that does not fit. Other directed windows put opcode-like constant payloads right after a start, which shows that payload words are never taken as starts. Biased random windows, where about half the words carry constant-flagged opcodes, cover both the slot-limited case and the window-limited case against a serial reference walk.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
   localparam int unsigned WORD_W       = 32;
   localparam int unsigned LEN_W        = 2;
   localparam int unsigned NEG_W        = 2;
   localparam logic [2:0]  CONST_MAJOR  = 3'b001;
   localparam int unsigned MAJOR_HI     = 31;
   localparam int unsigned CFLAG_BIT    = 15;
   localparam int unsigned NEG1_BIT     = 14;
   localparam int unsigned NEG2_BIT     = 13;
   localparam int unsigned WIDE_BIT     = 12;

   function automatic logic [LEN_W-1:0] word_len(input logic [WORD_W-1:0] w);
      if (w[MAJOR_HI -: 3] == CONST_MAJOR && w[CFLAG_BIT])
         return w[WIDE_BIT] ? LEN_W'(3) : LEN_W'(2);
      return LEN_W'(1);
   endfunction
endpackage

// File: rtl/ibp_len_decode.sv
module ibp_len_decode
   import ibp_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 32,
   parameter int unsigned POS       = 0,
   localparam int unsigned PTR_W    = $clog2(NUM_WORDS + 1)
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [LEN_W-1:0]  len_o,
   output logic [NEG_W-1:0]  neg_o,
   output logic              fits_o,
   output logic [PTR_W-1:0]  nxt_o
);
   logic [PTR_W:0] end_pos;

   always_comb begin
      len_o   = word_len(word_i);
      neg_o   = {word_i[NEG1_BIT], word_i[NEG2_BIT]};
      end_pos = (PTR_W + 1)'(POS) + (PTR_W + 1)'(len_o);
      fits_o  = end_pos <= (PTR_W + 1)'(NUM_WORDS);
      nxt_o   = fits_o ? end_pos[PTR_W-1:0] : PTR_W'(NUM_WORDS);
   end
endmodule

// File: rtl/ibp_start_resolver.sv
module ibp_start_resolver #(
   parameter int unsigned NUM_WORDS = 32,
   localparam int unsigned PTR_W    = $clog2(NUM_WORDS + 1),
   localparam int unsigned LEVELS   = $clog2(NUM_WORDS)
) (
   input  logic [NUM_WORDS-1:0][PTR_W-1:0] nxt_i,
   output logic [NUM_WORDS-1:0]            reach_o
);
   always_comb begin
      logic [PTR_W-1:0] jmp  [NUM_WORDS+1];
      logic [PTR_W-1:0] jnew [NUM_WORDS+1];
      logic [NUM_WORDS:0] mark;
      logic [NUM_WORDS:0] mnew;
      for (int i = 0; i < NUM_WORDS; i++) jmp[i] = nxt_i[i];
      jmp[NUM_WORDS] = PTR_W'(NUM_WORDS);
      mark    = '0;
      mark[0] = 1'b1;
      for (int lv = 0; lv < LEVELS; lv++) begin
         mnew = mark;
         for (int i = 0; i < NUM_WORDS; i++)
            if (mark[i]) mnew[jmp[i]] = 1'b1;
         for (int i = 0; i <= NUM_WORDS; i++) jnew[i] = jmp[jmp[i]];
         for (int i = 0; i <= NUM_WORDS; i++) jmp[i] = jnew[i];
         mark = mnew;
      end
      reach_o = mark[NUM_WORDS-1:0];
   end
endmodule

// File: rtl/ibp_compactor.sv
module ibp_compactor
   import ibp_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 32,
   parameter int unsigned MAX_OUT   = 16,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned CNT_W    = $clog2(MAX_OUT + 1),
   localparam int unsigned CONS_W   = $clog2(NUM_WORDS + 1)
) (
   input  logic [NUM_WORDS-1:0]            valid_i,
   input  logic [NUM_WORDS-1:0][LEN_W-1:0] len_i,
   input  logic [NUM_WORDS-1:0][NEG_W-1:0] neg_i,
   output logic [NUM_WORDS-1:0]            mask_o,
   output logic [MAX_OUT*IDX_W-1:0]        idx_o,
   output logic [MAX_OUT*LEN_W-1:0]        len_o,
   output logic [MAX_OUT*NEG_W-1:0]        neg_o,
   output logic [CNT_W-1:0]                count_o,
   output logic [CONS_W-1:0]               used_o
);
   always_comb begin
      int rank;
      rank    = 0;
      mask_o  = '0;
      idx_o   = '0;
      len_o   = '0;
      neg_o   = '0;
      used_o  = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (valid_i[i] && rank < MAX_OUT) begin
            mask_o[i]                   = 1'b1;
            idx_o[rank*IDX_W +: IDX_W]  = IDX_W'(i);
            len_o[rank*LEN_W +: LEN_W]  = len_i[i];
            neg_o[rank*NEG_W +: NEG_W]  = neg_i[i];
            used_o = CONS_W'(i) + CONS_W'(len_i[i]);
            rank++;
         end
      end
      count_o = CNT_W'(rank);
   end
endmodule

// File: rtl/ibp_parse_top.sv
module ibp_parse_top
   import ibp_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 32,
   parameter int unsigned MAX_OUT   = 16,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
   localparam int unsigned PTR_W    = $clog2(NUM_WORDS + 1),
   localparam int unsigned CNT_W    = $clog2(MAX_OUT + 1),
   localparam int unsigned CONS_W   = $clog2(NUM_WORDS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [NUM_WORDS*WORD_W-1:0] in_words,
   output logic                        out_valid,
   output logic [NUM_WORDS-1:0]        start_mask,
   output logic [MAX_OUT*IDX_W-1:0]    start_idx,
   output logic [MAX_OUT*LEN_W-1:0]    start_len,
   output logic [MAX_OUT*NEG_W-1:0]    start_neg,
   output logic [CNT_W-1:0]            start_count,
   output logic [CONS_W-1:0]           words_used
);
   generate
      if (NUM_WORDS < 2)
         $error("ibp_parse_top: NUM_WORDS must be at least 2");
      if (MAX_OUT < 1 || MAX_OUT > NUM_WORDS)
         $error("ibp_parse_top: MAX_OUT must lie in 1..NUM_WORDS");
   endgenerate

   logic [NUM_WORDS-1:0][LEN_W-1:0] w_len;
   logic [NUM_WORDS-1:0][NEG_W-1:0] w_neg;
   logic [NUM_WORDS-1:0][PTR_W-1:0] w_nxt;
   logic [NUM_WORDS-1:0]            w_fits;
   logic [NUM_WORDS-1:0]            reach;
   logic [NUM_WORDS-1:0]            c_mask;
   logic [MAX_OUT*IDX_W-1:0]        c_idx;
   logic [MAX_OUT*LEN_W-1:0]        c_len;
   logic [MAX_OUT*NEG_W-1:0]        c_neg;
   logic [CNT_W-1:0]                c_count;
   logic [CONS_W-1:0]               c_used;

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      ibp_len_decode #(.NUM_WORDS(NUM_WORDS), .POS(g)) dec_i (
         .word_i (in_words[g*WORD_W +: WORD_W]),
         .len_o  (w_len[g]),
         .neg_o  (w_neg[g]),
         .fits_o (w_fits[g]),
         .nxt_o  (w_nxt[g])
      );
   end

   ibp_start_resolver #(.NUM_WORDS(NUM_WORDS)) res_i (
      .nxt_i   (w_nxt),
      .reach_o (reach)
   );

   ibp_compactor #(.NUM_WORDS(NUM_WORDS), .MAX_OUT(MAX_OUT)) cmp_i (
      .valid_i (reach & w_fits),
      .len_i   (w_len),
      .neg_i   (w_neg),
      .mask_o  (c_mask),
      .idx_o   (c_idx),
      .len_o   (c_len),
      .neg_o   (c_neg),
      .count_o (c_count),
      .used_o  (c_used)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         start_mask  <= '0;
         start_idx   <= '0;
         start_len   <= '0;
         start_neg   <= '0;
         start_count <= '0;
         words_used  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            start_mask  <= c_mask;
            start_idx   <= c_idx;
            start_len   <= c_len;
            start_neg   <= c_neg;
            start_count <= c_count;
            words_used  <= c_used;
         end
      end
   end
endmodule

// File: rtl/ibp_parse_checker.sv
module ibp_parse_checker #(
   parameter int unsigned NUM_WORDS = 32,
   parameter int unsigned MAX_OUT   = 16,
   localparam int unsigned CNT_W    = $clog2(MAX_OUT + 1),
   localparam int unsigned CONS_W   = $clog2(NUM_WORDS + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 out_valid,
   input logic [NUM_WORDS-1:0] start_mask,
   input logic [CNT_W-1:0]     start_count,
   input logic [CONS_W-1:0]    words_used
);
   assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(start_mask) && $stable(words_used) && $stable(start_count)));
   assert_count_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(start_count) == $countones(start_mask)));
   assert_count_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(start_count) <= MAX_OUT));
   assert_first_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> start_mask[0]);
   assert_used_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(words_used) <= NUM_WORDS && words_used != '0));
endmodule

bind ibp_parse_top ibp_parse_checker #(.NUM_WORDS(NUM_WORDS), .MAX_OUT(MAX_OUT)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .start_mask  (start_mask),
   .start_count (start_count),
   .words_used  (words_used)
);

// File: tb/ibp_parse_top_tb_top.sv
module ibp_parse_top_tb_top;
   localparam int N  = 32;
   localparam int M  = 16;
   localparam int IW = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [N*32-1:0]  in_words = '0;
   logic             out_valid;
   logic [N-1:0]     start_mask;
   logic [M*IW-1:0]  start_idx;
   logic [M*2-1:0]   start_len;
   logic [M*2-1:0]   start_neg;
   logic [4:0]       start_count;
   logic [5:0]       words_used;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [N-1:0]    e_mask;
   logic [M*IW-1:0] e_idx;
   logic [M*2-1:0]  e_len;
   logic [M*2-1:0]  e_neg;
   logic [4:0]      e_count;
   logic [5:0]      e_used;

   always #2 clk = ~clk;

   ibp_parse_top dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
      .out_valid(out_valid), .start_mask(start_mask), .start_idx(start_idx),
      .start_len(start_len), .start_neg(start_neg), .start_count(start_count),
      .words_used(words_used)
   );

   function automatic int ref_len(input logic [31:0] w);
      if (w[31:29] == 3'b001 && w[15]) return w[12] ? 3 : 2;
      return 1;
   endfunction

   // Serial reference walk (R1, R2, R3, R4, R8)
   task automatic ref_walk(input logic [N*32-1:0] b);
      int pos, k, l;
      logic [31:0] w;
      e_mask = '0; e_idx = '0; e_len = '0; e_neg = '0;
      pos = 0; k = 0;
      while (pos < N && k < M) begin
         w = b[pos*32 +: 32];
         l = ref_len(w);
         if (pos + l > N) break;
         e_mask[pos] = 1'b1;
         e_idx[k*IW +: IW] = IW'(pos);
         e_len[k*2 +: 2]   = 2'(l);
         e_neg[k*2 +: 2]   = {w[14], w[13]};
         pos = pos + l;
         k++;
      end
      e_count = 5'(k);
      e_used  = 6'(pos);
   endtask

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [N*32-1:0] b);
      @(negedge clk);
      in_words = b;
      in_valid = 1'b1;
      ref_walk(b);
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 out_valid", 128'(out_valid), 128'(1));
      check("R2 start_mask", 128'(start_mask), 128'(e_mask));
      check("R4 start_count", 128'(start_count), 128'(e_count));
      check("R5 start_idx", 128'(start_idx), 128'(e_idx));
      check("R6 start_len", 128'(start_len), 128'(e_len));
      check("R7 start_neg", 128'(start_neg), 128'(e_neg));
      check("R8 words_used", 128'(words_used), 128'(e_used));
   endtask

   function automatic logic [31:0] mk_word(input int l, input bit n1, input bit n2);
      logic [31:0] w;
      w = $urandom;
      if (l == 1) w[15] = 1'b0;
      else begin
         w[31:29] = 3'b001; w[15] = 1'b1; w[12] = (l == 3);
      end
      w[14] = n1; w[13] = n2;
      return w;
   endfunction

   // Build a window from a list of lengths, payload words random
   function automatic logic [N*32-1:0] build(input int pat[]);
      logic [N*32-1:0] b;
      int pos;
      b = '0;
      for (int i = 0; i < N; i++) b[i*32 +: 32] = $urandom;
      pos = 0;
      foreach (pat[j]) begin
         if (pos < N) b[pos*32 +: 32] = mk_word(pat[j], 1'($urandom), 1'($urandom));
         pos += pat[j];
      end
      return b;
   endfunction

   initial begin
      logic [N*32-1:0] b;
      logic [N*32-1:0] held;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // Reset state (R9)
      check("R9 reset out_valid", 128'(out_valid), 128'(0));
      check("R9 reset start_mask", 128'(start_mask), 128'(0));
      check("R9 reset words_used", 128'(words_used), 128'(0));
      rst_n = 1'b1;

      // R1/R4: all one-word, capped at 16 slots
      b = build('{1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1});
      apply(b);
      check("R4 cap used", 128'(words_used), 128'(16));
      // R3: three-word instructions, last one at word 30 does not fit
      b = build('{3,3,3,3,3,3,3,3,3,3,3});
      apply(b);
      check("R3 truncated used", 128'(words_used), 128'(30));
      check("R3 truncated count", 128'(start_count), 128'(10));
      // R3: two-word instruction at word 31
      b = build('{3,3,3,3,3,3,3,3,3,2,2,2});
      apply(b);
      check("R3 two-word at 31", 128'(start_mask[31]), 128'(0));
      // R1: flag clear on 001 major is one word; wide bit alone irrelevant
      b = build('{2,2,2,2,2,2,2,2,2,2,2,2,2,2,2,2});
      b[0*32 +: 32] = 32'h2000_1000;
      apply(b);
      check("R1 flag clear len", 128'(start_len[1:0]), 128'(1));
      // R2: payload words that look like constant-carrying opcodes
      b = '0;
      for (int i = 0; i < N; i += 3) begin
         b[i*32 +: 32] = 32'h2000_9000;
         if (i + 1 < N) b[(i+1)*32 +: 32] = 32'h2000_9000;
         if (i + 2 < N) b[(i+2)*32 +: 32] = 32'h2000_9000;
      end
      apply(b);
      check("R2 payload not start", 128'(start_mask[1]), 128'(0));
      // R9: outputs hold while in_valid low
      held = {start_mask, words_used};
      @(negedge clk);
      in_words = ~in_words;
      @(negedge clk);
      check("R9 out_valid low", 128'(out_valid), 128'(0));
      check("R9 hold", 128'({start_mask, words_used}), 128'(held));

      // Biased random windows
      for (int v = 0; v < 400; v++) begin
         for (int i = 0; i < N; i++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(1, 0) == 1) begin
               w[31:29] = 3'b001;
               w[15] = ($urandom_range(3, 0) != 0);
            end
            b[i*32 +: 32] = w;
         end
         apply(b);
      end
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule